// File: doc/BRIEF.md
# Waveform Clock Squashing Chain

This block turns a fast, PLL-rate clock into a slower display-core clock. It does not gate or switch any clock. Each stage is an enable pulse in the fast clock domain. There are three stages in series.

- **Selectable divider.** It picks one of a few fixed divisors.
- **Squasher.** It walks a repeating bit pattern. A zero bit removes the current enable and a one bit lets it through, so the pattern can give non-integer ratios of the form ones/length.
- **Toggle stage.** It flips the output on every enable that survives, which halves the rate.

The divider and the squasher can each be bypassed. A bypassed stage's factor drops out of the overall ratio.

The output toggles at `f_in / div * (ones / length) / 2`. The divisor, the pattern and its length are taken from the inputs only when the pattern wraps, so a pattern is never cut off part-way. A pattern whose used bits are all zero is treated as an error. In that case every divider enable passes and a flag is raised.

Top module: `clkSquashChain`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the bit pointer, the divider phase and the output toggle are zero, so `clkOut` is 0. The power-on configuration is a one-bit all-ones pattern at divide-by-1. In that first cycle `divEn` and `sqEn` are both 1 and `waveErr` is 0.
- R2: `divSel` selects the divider pattern:
  - 2'b00 gives a `divEn` pulse every cycle.
  - 2'b01 gives two pulses in every three cycles: never two gaps in a row, and never three pulses in a row.
  - 2'b10 gives a pulse every other cycle.
  - 2'b11 behaves exactly like 2'b00.
- R3: With `divBypass` high, `divEn` is 1 on every cycle, whatever `divSel` is.
- R4: The pattern is read most-significant bit first. Bit 15 gates the first divider enable of each pass, bit 14 the second, and so on. A 0 bit suppresses `sqEn` for that enable.
- R5: `waveLen` gives the number of pattern bits used, from 1 to 16. A value of 0 or above 16 uses all 16 bits. The pointer wraps after that many divider enables.
- R6: `waveBits`, `waveLen` and `divSel` are sampled only on the divider enable that ends a pattern pass. A change in the middle of a pass does not affect the rest of that pass.
- R7: With `sqBypass` high, `sqEn` equals `divEn`.
- R8: If the used bits of the active pattern are all zero, `waveErr` is 1 and every divider enable appears on `sqEn`.
- R9: `clkOut` flips in the cycle after each `sqEn` and holds otherwise. `halfEn` is `sqEn` in the cycles where `clkOut` is 1, which is every second surviving enable.
- R10: Over a window that holds a whole number of divider and pattern periods, the count of `sqEn` equals cycles / divisor * ones / length. The divisor is 1, 1.5 or 2. Each bypass sets its stage's factor to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast PLL-rate clock |
| rstN | input | 1 | Asynchronous reset, active low |
| divSel | input | 2 | Divider choice: 00 /1, 01 /1.5, 10 /2, 11 /1 |
| divBypass | input | 1 | Force a divider enable on every cycle |
| sqBypass | input | 1 | Pass every divider enable through the squasher |
| waveBits | input | 16 | Squash pattern, read from the MSB down |
| waveLen | input | 5 | Number of pattern bits used (0 or >16 means 16) |
| divEn | output | 1 | Divider stage enable |
| sqEn | output | 1 | Squasher stage enable |
| halfEn | output | 1 | Enable at the divide-by-two stage rate |
| clkOut | output | 1 | Toggling output at the final rate |
| waveErr | output | 1 | Active pattern has no one bit in its used length |

## Verification
The assertions check these properties on every cycle:
- The pointer always stays below the active length.
- A wrap always returns the pointer to zero.
- The /2 and /1.5 divider patterns keep their gap structure.
- `sqEn` never fires without `divEn`.
- `clkOut` moves only after a surviving enable.
- `halfEn` never fires twice in a row.

Some behaviour only the bench's scenarios can show:
- The MSB-first bit order.
- The rule that new settings wait for the end of a pass.
- Clamping of the length field.
- The all-zero fallback.
- The exact overall ratio. This is shown by counting enables over windows that span whole periods, for several divisors, patterns and bypass settings.

// File: rtl/sqChainPkg.sv
package sqChainPkg;

  localparam int SQ_WAVE_W = 16;
  localparam int SQ_LEN_W  = $clog2(SQ_WAVE_W + 1);
  localparam int SQ_PTR_W  = $clog2(SQ_WAVE_W);

  typedef enum logic [1:0] {
    DIV_ONE     = 2'b00,
    DIV_ONEHALF = 2'b01,
    DIV_TWO     = 2'b10,
    DIV_RSVD    = 2'b11
  } divSel_e;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic                divEn;
    logic                load;
    logic [SQ_PTR_W-1:0] ptr;
    logic [SQ_LEN_W-1:0] len;
  } sqStrobe_t;

  function automatic logic [SQ_LEN_W-1:0] clampLen(input logic [SQ_LEN_W-1:0] raw);
    if (raw == '0 || raw > SQ_LEN_W'(SQ_WAVE_W)) return SQ_LEN_W'(SQ_WAVE_W);
    return raw;
  endfunction

  function automatic logic [1:0] divPeriod(input divSel_e sel);
    case (sel)
      DIV_ONEHALF: return 2'd3;
      DIV_TWO:     return 2'd2;
      default:     return 2'd1;
    endcase
  endfunction

  function automatic logic divPulse(input divSel_e sel, input logic [1:0] ph);
    case (sel)
      DIV_ONEHALF: return ph != 2'd2;
      DIV_TWO:     return ph == 2'd0;
      default:     return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/sqCtrl.sv
module sqCtrl
  import sqChainPkg::*;
#(
  parameter int WAVE_W = SQ_WAVE_W,
  parameter int LEN_W  = SQ_LEN_W,
  parameter int PTR_W  = SQ_PTR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       divSelIn,
  input  logic [LEN_W-1:0] waveLenIn,
  input  logic             divBypass,
  output sqStrobe_t        strobe
);

  divSel_e          divSelQ;
  divSel_e          divSelNext;
  logic [1:0]       phQ;
  logic [1:0]       phNext;
  logic [2:0]       phInc;
  logic [PTR_W-1:0] ptrQ;
  logic [PTR_W-1:0] ptrNext;
  logic [LEN_W-1:0] lenQ;
  logic             divEn;
  logic             ptrLast;
  logic             load;

  // Divider stage
  assign divEn = divBypass | divPulse(divSelQ, phQ);

  // Pattern position and the wrap-time load
  assign ptrLast = ({1'b0, ptrQ} == (lenQ - LEN_W'(1)));
  assign load    = divEn & ptrLast;

  always_comb begin
    divSelNext = load ? divSel_e'(divSelIn) : divSelQ;
    phInc      = {1'b0, phQ} + 3'd1;
    phNext     = (phInc >= {1'b0, divPeriod(divSelNext)}) ? 2'd0 : phInc[1:0];
    if (!divEn)       ptrNext = ptrQ;
    else if (ptrLast) ptrNext = '0;
    else              ptrNext = ptrQ + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divSelQ <= DIV_ONE;
      phQ     <= 2'd0;
      ptrQ    <= '0;
      lenQ    <= LEN_W'(1);
    end else begin
      divSelQ <= divSelNext;
      phQ     <= phNext;
      ptrQ    <= ptrNext;
      if (load) lenQ <= clampLen(waveLenIn);
    end
  end

  always_comb begin
    strobe.divEn = divEn;
    strobe.load  = load;
    strobe.ptr   = ptrQ;
    strobe.len   = lenQ;
  end

  // R5: pointer never reaches the active length
  p_ptr_in_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, ptrQ} < lenQ);

  // R6: a load restarts the pattern from its first bit
  p_wrap_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (ptrQ == '0));

  // R2: divide-by-two leaves a gap after each pulse
  p_div_two_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!divBypass && divSelQ == DIV_TWO && divEn && !load) |=> (divBypass || !divEn));

  // R2: divide-by-1.5 never leaves two gaps in a row
  p_onehalf_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!divBypass && divSelQ == DIV_ONEHALF && !divEn) |=> divEn);

endmodule

// File: rtl/sqPath.sv
module sqPath
  import sqChainPkg::*;
#(
  parameter int WAVE_W = SQ_WAVE_W,
  parameter int LEN_W  = SQ_LEN_W,
  parameter int PTR_W  = SQ_PTR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  sqStrobe_t         strobe,
  input  logic [WAVE_W-1:0] waveIn,
  input  logic              sqBypass,
  output logic              sqEn,
  output logic              halfEn,
  output logic              clkOut,
  output logic              waveErr
);

  logic [WAVE_W-1:0] waveQ;
  logic [WAVE_W-1:0] useMask;
  logic [PTR_W-1:0]  bitIdx;
  logic              curBit;
  logic              togQ;

  // Top 'len' bits of the pattern are in use
  for (genvar i = 0; i < WAVE_W; i++) begin : g_mask
    assign useMask[WAVE_W-1-i] = (strobe.len > LEN_W'(i));
  end

  assign bitIdx  = PTR_W'(WAVE_W - 1) - strobe.ptr;
  assign curBit  = waveQ[bitIdx];
  assign waveErr = ~|(waveQ & useMask);
  assign sqEn    = strobe.divEn & (sqBypass | waveErr | curBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waveQ <= '1;
      togQ  <= 1'b0;
    end else begin
      if (strobe.load) waveQ <= waveIn;
      if (sqEn)        togQ  <= ~togQ;
    end
  end

  assign clkOut = togQ;
  assign halfEn = sqEn & togQ;

  // R9: output flips after each surviving enable
  p_toggle_on_en_r9: assert property (@(posedge clk) disable iff (!rstN)
    sqEn |=> (clkOut != $past(clkOut)));

  // R9: output holds when no enable survives
  p_hold_no_en_r9: assert property (@(posedge clk) disable iff (!rstN)
    !sqEn |=> $stable(clkOut));

  // R9: halved-rate enable never fires back to back
  p_half_spaced_r9: assert property (@(posedge clk) disable iff (!rstN)
    halfEn |=> !halfEn);

  // R6: pattern only changes on a wrap load
  p_wave_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(waveQ));

endmodule

// File: rtl/clkSquashChain.sv
module clkSquashChain
  import sqChainPkg::*;
#(
  parameter int WAVE_W = SQ_WAVE_W,
  parameter int LEN_W  = SQ_LEN_W,
  parameter int PTR_W  = SQ_PTR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        divSel,
  input  logic              divBypass,
  input  logic              sqBypass,
  input  logic [WAVE_W-1:0] waveBits,
  input  logic [LEN_W-1:0]  waveLen,
  output logic              divEn,
  output logic              sqEn,
  output logic              halfEn,
  output logic              clkOut,
  output logic              waveErr
);

  sqStrobe_t strobe;

  sqCtrl #(.WAVE_W(WAVE_W), .LEN_W(LEN_W), .PTR_W(PTR_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .divSelIn  (divSel),
    .waveLenIn (waveLen),
    .divBypass (divBypass),
    .strobe    (strobe)
  );

  sqPath #(.WAVE_W(WAVE_W), .LEN_W(LEN_W), .PTR_W(PTR_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .waveIn   (waveBits),
    .sqBypass (sqBypass),
    .sqEn     (sqEn),
    .halfEn   (halfEn),
    .clkOut   (clkOut),
    .waveErr  (waveErr)
  );

  assign divEn = strobe.divEn;

  // R4: the squasher only removes enables, never adds them
  p_sq_subset_r4: assert property (@(posedge clk) disable iff (!rstN)
    sqEn |-> divEn);

  // R7: squasher bypass passes every divider enable
  p_sq_bypass_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sqBypass && divEn) |-> sqEn);

endmodule

// File: tb/sim_clkSquashChain.sv
module sim_clkSquashChain;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 120;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  divSel = 2'b00;
  logic        divBypass = 1'b0;
  logic        sqBypass = 1'b0;
  logic [15:0] waveBits = 16'hFFFF;
  logic [4:0]  waveLen = 5'd16;
  logic        divEn, sqEn, halfEn, clkOut, waveErr;

  int nChk = 0;
  int nBad = 0;
  bit doneFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkSquashChain u0 (
    .clk(clk), .rstN(rstN), .divSel(divSel), .divBypass(divBypass),
    .sqBypass(sqBypass), .waveBits(waveBits), .waveLen(waveLen),
    .divEn(divEn), .sqEn(sqEn), .halfEn(halfEn), .clkOut(clkOut),
    .waveErr(waveErr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int effLen(input logic [4:0] ln);
    return (ln == 0 || ln > 16) ? 16 : int'(ln);
  endfunction

  function automatic int onesUsed(input logic [15:0] wv, input int len);
    int n = 0;
    for (int i = 0; i < len; i++) n += int'(wv[15-i]);
    return n;
  endfunction

  // R1: reset state and the first cycle after release
  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0;
    divSel = 2'b00; divBypass = 1'b0; sqBypass = 1'b0;
    waveBits = 16'hF000; waveLen = 5'd8;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "clkOut in reset", int'(clkOut), 0);
    chk("R1", "waveErr in reset", int'(waveErr), 0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1", "divEn after release", int'(divEn), 1);
    chk("R1", "sqEn after release", int'(sqEn), 1);
    chk("R1", "clkOut after release", int'(clkOut), 0);
  endtask

  // R6 and R4: mid-pass change waits for the wrap; MSB-first order
  task automatic testWrapLoad();
    int expSeq [16] = '{1,1,1,1,0,0,0,0, 0,0,0,0,1,1,1,1};
    int bad = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (k == 2) waveBits = 16'h0F00;
      #1;
      if (int'(sqEn) != expSeq[k]) begin
        bad++;
        $display("FAIL R6 sqEn at step %0d: actual=%0d expected=%0d", k, sqEn, expSeq[k]);
      end
    end
    nChk++;
    if (bad != 0) nBad++;
  endtask

  // R2 / R3: divider pulse structure
  task automatic testDivPattern(input string req, input logic [1:0] sel, input bit dBy);
    int cnt = 0;
    int bad = 0;
    int prev2 = -1;
    int prev1 = -1;
    int cur;
    int expCnt;
    @(negedge clk);
    divSel = sel; divBypass = dBy; sqBypass = 1'b1;
    repeat (SETTLE) @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      #1;
      cur = int'(divEn);
      cnt += cur;
      if (!dBy && sel == 2'b01) begin
        if (prev1 == 0 && cur == 0) bad++;
        if (prev2 == 1 && prev1 == 1 && cur == 1) bad++;
      end
      if (!dBy && sel == 2'b10 && prev1 == cur) bad++;
      prev2 = prev1;
      prev1 = cur;
    end
    if (dBy || sel == 2'b00 || sel == 2'b11) expCnt = 12;
    else if (sel == 2'b01) expCnt = 8;
    else expCnt = 6;
    chk(req, "divEn pulses in 12 cycles", cnt, expCnt);
    chk(req, "divEn spacing violations", bad, 0);
    divBypass = 1'b0; sqBypass = 1'b0;
  endtask

  // R10 with R9 consistency: rate counts over whole periods
  task automatic runRate(input string req, input logic [1:0] sel, input bit dBy,
                         input bit sBy, input logic [15:0] wv, input logic [4:0] ln);
    int len = effLen(ln);
    int ones = onesUsed(wv, len);
    bit zero = (ones == 0);
    int passOnes = (sBy || zero) ? len : ones;
    int win = 120 * len;
    int expDiv, expSq;
    int cDiv = 0, cSq = 0, cHalf = 0, togBad = 0;
    logic prevClk = 1'b0, prevSq = 1'b0;
    bit prevValid = 0;
    @(negedge clk);
    divSel = sel; divBypass = dBy; sqBypass = sBy; waveBits = wv; waveLen = ln;
    repeat (SETTLE) @(negedge clk);
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      #1;
      cDiv += int'(divEn);
      cSq += int'(sqEn);
      cHalf += int'(halfEn);
      if (prevValid && clkOut != (prevClk ^ prevSq)) togBad++;
      prevClk = clkOut; prevSq = sqEn; prevValid = 1;
    end
    if (dBy || sel == 2'b00 || sel == 2'b11) expDiv = win;
    else if (sel == 2'b01) expDiv = (win * 2) / 3;
    else expDiv = win / 2;
    expSq = (expDiv * passOnes) / len;
    chk(req, "divEn count", cDiv, expDiv);
    chk(req, "sqEn count", cSq, expSq);
    chk("R9", "halfEn count", cHalf, expSq / 2);
    chk("R9", "clkOut toggle mismatches", togBad, 0);
    chk(req, "waveErr level", int'(waveErr), int'(zero && !sBy ? 1'b1 : zero));
  endtask

  initial begin
    testReset();
    testWrapLoad();
    testDivPattern("R2", 2'b00, 1'b0);
    testDivPattern("R2", 2'b01, 1'b0);
    testDivPattern("R2", 2'b10, 1'b0);
    testDivPattern("R2", 2'b11, 1'b0);
    testDivPattern("R3", 2'b10, 1'b1);
    runRate("R10", 2'b10, 1'b0, 1'b0, 16'hAAAA, 5'd16);
    runRate("R10", 2'b01, 1'b0, 1'b0, 16'hE000, 5'd5);
    runRate("R4",  2'b00, 1'b0, 1'b0, 16'hC000, 5'd3);
    runRate("R5",  2'b00, 1'b0, 1'b0, 16'h8001, 5'd0);
    runRate("R5",  2'b10, 1'b0, 1'b0, 16'hC000, 5'd20);
    runRate("R7",  2'b10, 1'b0, 1'b1, 16'h8000, 5'd4);
    runRate("R3",  2'b10, 1'b1, 1'b0, 16'hF0F0, 5'd8);
    runRate("R8",  2'b01, 1'b0, 1'b0, 16'h00FF, 5'd8);
    runRate("R8",  2'b00, 1'b0, 1'b0, 16'h0000, 5'd16);
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!doneFlag) begin
      doneFlag = 1;
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule